// File: doc/BRIEF.md
# Standby Timer-Mode Power Controller

This controller puts a small microcontroller into a timer-only standby state and brings it back out. Software enters standby by clearing the entry bit of a small mode-control register. The entry is accepted only while the core runs from the PLL or from the main oscillator, and only when no interrupt request is pending. In standby the main oscillator is stopped and the CPU and peripheral clock gate is closed. The timer clock stays enabled, so the interval timer and the watch timer keep counting. No reset or clear is issued, so registers and RAM keep their contents.

Any request whose 3-bit level is not the disabled code 111 ends standby. The wake-up does not depend on whether the CPU will accept the interrupt. The oscillator restarts at once. The CPU clock stays gated until a programmable number of ticks from the interval timer have elapsed, which gives the oscillator time to settle. When the gate reopens, a one-cycle wake pulse reports whether the CPU will service the request. The pins either hold their levels or float for the whole of standby and warm-up, as chosen by a register bit. An external reset also ends standby and asks the clock selector to return to main-clock mode.

Top module: `stby_ctrl`

## Requirements
- R1: A write with `regWdata[0]`=0 while running and with `clkMode` 00 (main) or 01 (PLL) enters standby at that clock edge: `oscEn`=0 and `cpuClkEn`=0 from then on. With `clkMode` 10 or 11 the write is refused and the block keeps running.
- R2: If any `irqReq` bit is 1 at the edge of the entry write, whatever its level, the entry is refused and `cpuClkEn` and `oscEn` stay 1.
- R3: `tmrClkEn` is 1 in every state. Register fields `regRdata[5:2]` (stabilisation count) and `regRdata[1]` (pin mode) keep their values through standby and wake-up.
- R4: While in standby or warm-up, `pinHold`=1 if bit 1 is 0 and `pinHiZ`=1 if bit 1 is 1. While running, both are 0.
- R5: In standby, requests whose level field `irqLvl[3i+2:3i]` equals 111 do not wake the block.
- R6: In standby, a request with level other than 111 moves the block to warm-up at the next edge: `oscEn`=1 and `cpuClkEn`=0.
- R7: Warm-up loads a counter with N = bit field [5:2]. At each edge, if the counter is 0 the block runs again (`cpuClkEn`=1). Otherwise a 1 on `tbTick` decrements the counter.
- R8: `wakePulse` is 1 for exactly the first running cycle after warm-up. `wakeSvc` is 1 with it when `cpuIFlag` is 1 and some request with a level other than 111 has a level numerically below `cpuIlm` (lower value = higher priority).
- R9: `regRdata[0]` reads 0 in standby and warm-up and reads 1 while running, so re-entry needs a new write of 0.
- R10: An active-low `rstN` forces running state at once with `regRdata`=000001. `forceMain` is 1 during reset and drops after the first clock edge.
- R11: Register writes outside the running state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (from the always-on timer domain) |
| rstN | input | 1 | External reset, active low, asynchronous |
| clkMode | input | 2 | Current clock mode: 00 main, 01 PLL, 10/11 other |
| regWe | input | 1 | Mode-control register write strobe |
| regWdata | input | 6 | Write data {stab[3:0], pin mode, entry bit} |
| regRdata | output | 6 | Register readback, same layout |
| irqReq | input | NSRC | Per-source interrupt request lines |
| irqLvl | input | 3*NSRC | Per-source 3-bit levels, source i at [3i+2:3i] |
| cpuIFlag | input | 1 | CPU global interrupt enable flag |
| cpuIlm | input | 3 | CPU interrupt level mask |
| tbTick | input | 1 | Tick from the running interval timer |
| oscEn | output | 1 | Main oscillator enable |
| cpuClkEn | output | 1 | CPU and peripheral clock gate enable |
| tmrClkEn | output | 1 | Timer clock enable |
| pinHold | output | 1 | External pins hold their levels |
| pinHiZ | output | 1 | External pins float |
| wakePulse | output | 1 | One-cycle pulse when the clock gate reopens |
| wakeSvc | output | 1 | The waking interrupt will be serviced |
| forceMain | output | 1 | Request to return to main-clock mode after reset |

## Verification
The hardest situation to reach is a warm-up that lasts exactly as long as the programmed count. This happens while masked level-111 requests and waking requests overlap, and while the tick input arrives irregularly. The stimulus enters standby with a random count and pin mode, and first holds only level-111 requests to show they are ignored. It then raises one waking request with a random level, mask and global flag, and toggles the tick at random. A bench model counts the ticks alongside the design, so the pulse cycle and the service decision are predicted edge by edge.

// File: rtl/stby_pkg.sv
package stby_pkg;
  localparam logic [1:0] MODE_MAIN = 2'b00;
  localparam logic [1:0] MODE_PLL  = 2'b01;

  typedef enum logic [1:0] {ST_RUN, ST_STBY, ST_WARM} stbyState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic enterStby;
    logic loadCnt;
    logic countEn;
    logic exitStby;
    logic inRun;
  } ctlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic entryReq;
    logic irqAny;
    logic irqWake;
    logic irqSvc;
    logic cntZero;
  } dpStatus_t;
endpackage

// File: rtl/stby_datapath.sv
module stby_datapath
  import stby_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int LVLW  = 3,
  parameter int STABW = 4,
  localparam int REGW = STABW + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        clkMode,
  input  logic              regWe,
  input  logic [REGW-1:0]   regWdata,
  input  logic [NSRC-1:0]   irqReq,
  input  logic [NSRC*LVLW-1:0] irqLvl,
  input  logic              cpuIFlag,
  input  logic [LVLW-1:0]   cpuIlm,
  input  logic              tbTick,
  input  ctlStrobe_t        strobe,
  output dpStatus_t         status,
  output logic [REGW-1:0]   regRdata,
  output logic              pinFloat
);
  logic             tmrBit;
  logic             pinFloatQ;
  logic [STABW-1:0] stabQ;
  logic [STABW-1:0] cnt;
  logic [NSRC-1:0]  wakeVec;
  logic [NSRC-1:0]  svcVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrBit    <= 1'b1;
      pinFloatQ <= 1'b0;
      stabQ     <= '0;
    end else begin
      if (regWe && strobe.inRun) begin
        pinFloatQ <= regWdata[1];
        stabQ     <= regWdata[REGW-1:2];
      end
      if (strobe.enterStby)     tmrBit <= 1'b0;
      else if (strobe.exitStby) tmrBit <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 cnt <= '0;
    else if (strobe.loadCnt)                   cnt <= stabQ;
    else if (strobe.countEn && tbTick && cnt != '0) cnt <= cnt - 1'b1;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [LVLW-1:0] lvl;
    assign lvl        = irqLvl[i*LVLW +: LVLW];
    assign wakeVec[i] = irqReq[i] && (lvl != '1);
    assign svcVec[i]  = wakeVec[i] && (lvl < cpuIlm);
  end

  always_comb begin
    status.irqAny   = |irqReq;
    status.irqWake  = |wakeVec;
    status.irqSvc   = cpuIFlag && (|svcVec);
    status.cntZero  = (cnt == '0);
    status.entryReq = regWe && strobe.inRun && !regWdata[0] && !status.irqAny &&
                      (clkMode == MODE_MAIN || clkMode == MODE_PLL);
  end

  assign regRdata = {stabQ, pinFloatQ, tmrBit};
  assign pinFloat = pinFloatQ;

  // R7
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countEn && !strobe.loadCnt && !tbTick) |=> $stable(cnt));

  // R11
  cfg_retain_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.inRun |=> $stable({stabQ, pinFloatQ}));
endmodule

// File: rtl/stby_control.sv
module stby_control
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  status,
  input  logic       pinFloat,
  output ctlStrobe_t strobe,
  output logic       oscEn,
  output logic       cpuClkEn,
  output logic       tmrClkEn,
  output logic       pinHold,
  output logic       pinHiZ,
  output logic       wakePulse,
  output logic       wakeSvc,
  output logic       forceMain
);
  stbyState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:  if (status.entryReq) stateNext = ST_STBY;
      ST_STBY: if (status.irqWake)  stateNext = ST_WARM;
      ST_WARM: if (status.cntZero)  stateNext = ST_RUN;
      default: stateNext = ST_RUN;
    endcase
  end

  always_comb begin
    strobe.inRun     = (state == ST_RUN);
    strobe.enterStby = (state == ST_RUN)  && status.entryReq;
    strobe.loadCnt   = (state == ST_STBY) && status.irqWake;
    strobe.countEn   = (state == ST_WARM);
    strobe.exitStby  = (state == ST_WARM) && status.cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      wakePulse <= 1'b0;
      wakeSvc   <= 1'b0;
      forceMain <= 1'b1;
    end else begin
      state     <= stateNext;
      wakePulse <= strobe.exitStby;
      wakeSvc   <= strobe.exitStby && status.irqSvc;
      forceMain <= 1'b0;
    end
  end

  assign oscEn    = (state != ST_STBY);
  assign cpuClkEn = (state == ST_RUN);
  assign tmrClkEn = 1'b1;
  assign pinHold  = (state != ST_RUN) && !pinFloat;
  assign pinHiZ   = (state != ST_RUN) && pinFloat;

  // R2
  no_entry_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && status.irqAny) |=> state == ST_RUN);

  // R5
  lvl7_no_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STBY && !status.irqWake) |=> state == ST_STBY);

  // R7
  warm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WARM && !status.cntZero) |=> state == ST_WARM);

  // R8
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (cpuClkEn && $past(state) == ST_WARM));
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int LVLW  = 3,
  parameter int STABW = 4,
  localparam int REGW = STABW + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           clkMode,
  input  logic                 regWe,
  input  logic [REGW-1:0]      regWdata,
  output logic [REGW-1:0]      regRdata,
  input  logic [NSRC-1:0]      irqReq,
  input  logic [NSRC*LVLW-1:0] irqLvl,
  input  logic                 cpuIFlag,
  input  logic [LVLW-1:0]      cpuIlm,
  input  logic                 tbTick,
  output logic                 oscEn,
  output logic                 cpuClkEn,
  output logic                 tmrClkEn,
  output logic                 pinHold,
  output logic                 pinHiZ,
  output logic                 wakePulse,
  output logic                 wakeSvc,
  output logic                 forceMain
);
  ctlStrobe_t strobe;
  dpStatus_t  status;
  logic       pinFloat;

  stby_datapath #(.NSRC(NSRC), .LVLW(LVLW), .STABW(STABW)) u_dp (
    .clk(clk), .rstN(rstN), .clkMode(clkMode), .regWe(regWe), .regWdata(regWdata),
    .irqReq(irqReq), .irqLvl(irqLvl), .cpuIFlag(cpuIFlag), .cpuIlm(cpuIlm),
    .tbTick(tbTick), .strobe(strobe), .status(status), .regRdata(regRdata),
    .pinFloat(pinFloat)
  );

  stby_control u_ctl (
    .clk(clk), .rstN(rstN), .status(status), .pinFloat(pinFloat), .strobe(strobe),
    .oscEn(oscEn), .cpuClkEn(cpuClkEn), .tmrClkEn(tmrClkEn), .pinHold(pinHold),
    .pinHiZ(pinHiZ), .wakePulse(wakePulse), .wakeSvc(wakeSvc), .forceMain(forceMain)
  );
endmodule

// File: tb/stby_ctrl_test.sv
`timescale 1ns/100ps
module stby_ctrl_test;
  localparam int NSRC = 4;

  logic clk = 1'b0;
  logic rstN;
  logic [1:0] clkMode;
  logic regWe;
  logic [5:0] regWdata, regRdata;
  logic [NSRC-1:0] irqReq;
  logic [NSRC*3-1:0] irqLvl;
  logic cpuIFlag;
  logic [2:0] cpuIlm;
  logic tbTick;
  logic oscEn, cpuClkEn, tmrClkEn, pinHold, pinHiZ, wakePulse, wakeSvc, forceMain;

  int vectors = 0;
  int miscomp = 0;

  always #2.5 clk = ~clk;

  stby_ctrl uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit expEntry(input int mode, input bit pend);
    return (mode < 2) && !pend;
  endfunction

  function automatic bit expService(input bit iflag, input int lvl, input int ilm);
    return iflag && (lvl != 7) && (lvl < ilm);
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  endtask

  // fm/fp: forced mode / pending (-1 = random)
  task automatic trial(input int fm, input int fp);
    int stab, mode, src, lvl, ilm, cnt;
    bit pf, pend, ent, iflag, svc, tk;
    logic [5:0] junk;
    stab = $urandom_range(0, 5);
    pf   = 1'($urandom_range(0, 1));
    mode = (fm < 0) ? $urandom_range(0, 3) : fm;
    pend = (fp < 0) ? ($urandom_range(0, 3) == 0) : (fp != 0);
    ent  = expEntry(mode, pend);
    @(negedge clk);
    clkMode = 2'(mode);
    irqReq = '0;
    irqLvl = 12'($urandom);
    if (pend) irqReq[$urandom_range(0, NSRC-1)] = 1'b1;
    regWe = 1'b1;
    regWdata = {4'(stab), pf, 1'b0};
    @(posedge clk); #1;
    chk(pend ? "R2" : "R1", cpuClkEn, !ent);
    chk(pend ? "R2" : "R1", oscEn, !ent);
    chk("R4", pinHiZ, ent && pf);
    chk("R4", pinHold, ent && !pf);
    chk("R9", regRdata[0], !ent);
    chk("R3", regRdata[5:1], {4'(stab), pf});
    chk("R3", tmrClkEn, 1);
    @(negedge clk);
    regWe = 1'b0;
    irqReq = '0;
    if (!ent) return;
    // masked-level requests and an ignored write
    junk = 6'($urandom);
    regWe = 1'b1;
    regWdata = junk;
    irqReq = 4'($urandom_range(1, 15));
    irqLvl = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R5", cpuClkEn, 0);
    chk("R5", oscEn, 0);
    chk("R3", tmrClkEn, 1);
    chk("R11", regRdata[5:1], {4'(stab), pf});
    // waking request
    @(negedge clk);
    regWe = 1'b0;
    src = $urandom_range(0, NSRC-1);
    lvl = $urandom_range(0, 6);
    ilm = $urandom_range(0, 7);
    iflag = 1'($urandom_range(0, 1));
    irqReq = 4'($urandom) | (4'b1 << src);
    irqLvl = '1;
    irqLvl[src*3 +: 3] = 3'(lvl);
    cpuIFlag = iflag;
    cpuIlm = 3'(ilm);
    svc = expService(iflag, lvl, ilm);
    tbTick = 1'($urandom_range(0, 1));
    @(posedge clk); #1;
    chk("R6", oscEn, 1);
    chk("R6", cpuClkEn, 0);
    chk("R4", pinHiZ, pf);
    chk("R4", pinHold, !pf);
    chk("R9", regRdata[0], 0);
    cnt = stab;
    forever begin
      @(negedge clk);
      tk = 1'($urandom_range(0, 1));
      tbTick = tk;
      @(posedge clk); #1;
      if (cnt == 0) begin
        chk("R7", cpuClkEn, 1);
        chk("R8", wakePulse, 1);
        chk("R8", wakeSvc, svc);
        chk("R9", regRdata[0], 1);
        chk("R4", pinHold | pinHiZ, 0);
        break;
      end
      if (tk) cnt--;
      chk("R7", cpuClkEn, 0);
      chk("R8", wakePulse, 0);
    end
    @(negedge clk);
    irqReq = '0;
    @(posedge clk); #1;
    chk("R8", wakePulse, 0);
    chk("R3", regRdata[5:1], {4'(stab), pf});
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    miscomp++;
    $display("FAIL watchdog: got %0d expected 0", cyc);
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; clkMode = 2'b00; regWe = 1'b0; regWdata = '0; irqReq = '0;
    irqLvl = '1; cpuIFlag = 1'b0; cpuIlm = 3'd0; tbTick = 1'b0;
    @(negedge clk);
    chk("R10", forceMain, 1);
    chk("R10", regRdata, 1);
    chk("R10", cpuClkEn, 1);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R10", forceMain, 0);
    // directed corners
    trial(2, 0);   // sub-clock mode refused (R1)
    trial(3, 0);
    trial(0, 1);   // pending request refused (R2)
    trial(1, 0);   // PLL entry (R1)
    trial(0, 0);
    for (int i = 0; i < 60; i++) trial(-1, -1);
    // reset during standby (R10)
    @(negedge clk);
    clkMode = 2'b00; irqReq = '0; regWe = 1'b1; regWdata = 6'b000110;
    @(posedge clk); #1;
    chk("R1", cpuClkEn, 0);
    @(negedge clk);
    regWe = 1'b0;
    rstN = 1'b0;
    #1;
    chk("R10", cpuClkEn, 1);
    chk("R10", oscEn, 1);
    chk("R10", forceMain, 1);
    chk("R10", regRdata, 1);
    chk("R10", pinHiZ, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R10", forceMain, 0);
    summary();
  end
endmodule